// File: doc/BRIEF.md
# Periodic Interrupt Timer with Coalescing

This block produces a periodic interrupt from a 32768 Hz tick enable, in the manner of a real-time clock's periodic interrupt source. A 4-bit rate code picks a power-of-two period, and each event lands on a tick count that is a whole multiple of that period. An event sets the two top bits of an 8-bit status register and raises the interrupt line.

Software can be slow to service the line. When that happens, an event that fires while the status flags are still set is not lost. With coalescing enabled, the block counts it as a missed interrupt instead. Each read of the status register lowers the line. If missed interrupts are outstanding, the read re-raises the line and keeps the flags. An acknowledge input, sampled in the cycle after that read, reports whether the replayed interrupt was taken. Only then is the missed count decremented. When the rate code changes, the count is rescaled so that it still represents the same span of time.

Top module: `pit_coalesce`

## Requirements
- R1: While reset is asserted and right after it, `irqOut` is 0 and `statusData` is 0x00.
- R2: Rate codes 3 to 15 give a period of 2^(code-1) ticks. Codes 1 and 2 give 128 and 256 ticks.
- R3: A free-running count of `tickEn` pulses starts at 0 after reset and runs whether the timer is enabled or not. An event fires on the tick that brings this count to a whole multiple of the period. `irqOut` and the status flags change at that clock edge.
- R4: An event sets `statusData` to 0xC0 (bits 7 and 6) and raises `irqOut`.
- R5: If an event fires while the flags are set and `coalesceOn` is 1, the missed count goes up by one and the flags and line are unchanged. With `coalesceOn` at 0, the count is untouched and the line stays high.
- R6: During a `statusRd` cycle, `statusData` shows the current flags. If the missed count is zero, the edge ending that cycle clears the status to 0x00 and lowers `irqOut`. An event in that same cycle is applied after the read.
- R7: A read with a nonzero missed count keeps the status at 0xC0 and `irqOut` high. `delivered` is sampled in the next cycle. If it is 1, the count drops by one. If it is 0, the count is kept.
- R8: When the enabled rate code changes its period, the missed count becomes count × old period / new period, rounded down.
- R9: A rate code of 0 or `periodicOn` at 0 disables events and clears the missed count to zero.
- R10: The missed count saturates at its maximum (2^CNT_W − 1) rather than wrapping, both on increments and on a rescale upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle 32768 Hz tick enable |
| rateCode | input | 4 | Period select; 0 disables |
| periodicOn | input | 1 | Periodic interrupt enable |
| coalesceOn | input | 1 | Count missed events instead of dropping them |
| statusRd | input | 1 | Status register read strobe |
| delivered | input | 1 | Replayed interrupt accepted, valid the cycle after a read |
| statusData | output | 8 | Status register contents |
| irqOut | output | 1 | Interrupt line |

## Verification
Directed sequences cover several cases. Tick phases before enabling show that events land on period boundaries rather than at an offset from enabling. Period measurements on codes 1, 2, 3 and 7 separate the remapped codes from the plain power-of-two codes. Counted tick bursts followed by drains with `delivered` at 0 and at 1 show whether a replay only consumes a missed interrupt when it is acknowledged. Rate changes in both directions, plus one change that overflows an 8-bit count, distinguish floor division from rounding and saturation from wrap-around. Seeded random streams of ticks, reads, acknowledges, rate changes and disables then compare both outputs every cycle against a bench model. These streams catch ordering faults between a read, an event and a rescale that fall in the same cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int RATE_W = 4;
  localparam int LOG_W  = 4;

  typedef struct packed {
    logic fire;
    logic rdStatus;
    logic rateChange;
    logic clearCount;
  } pitStrobe_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              periodicOn,
  input  logic              statusRd,
  output pitStrobe_t        stb,
  output logic [LOG_W-1:0]  curLog,
  output logic [LOG_W-1:0]  prevLog
);
  logic [TICK_W-1:0] tickCount;
  logic [TICK_W-1:0] nextTick;
  logic [TICK_W-1:0] periodMask;
  logic [LOG_W-1:0]  storedLog;
  logic              enabled;

  function automatic logic [LOG_W-1:0] codeToLog(input logic [RATE_W-1:0] code);
    logic [RATE_W:0] adj;
    adj = (code < RATE_W'(3)) ? ({1'b0, code} + (RATE_W+1)'(7)) : {1'b0, code};
    return LOG_W'(adj - (RATE_W+1)'(1));
  endfunction

  assign enabled    = periodicOn && (rateCode != '0);
  assign curLog     = codeToLog(rateCode);
  assign prevLog    = storedLog;
  assign nextTick   = tickCount + TICK_W'(1);
  assign periodMask = (TICK_W'(1) << curLog) - TICK_W'(1);

  always_comb begin
    stb.fire       = tickEn && enabled && ((nextTick & periodMask) == '0);
    stb.rdStatus   = statusRd;
    stb.rateChange = enabled && (curLog != storedLog);
    stb.clearCount = !enabled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount <= '0;
      storedLog <= '0;
    end else begin
      if (tickEn) tickCount <= nextTick;
      if (enabled) storedLog <= curLog;
    end
  end
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pitStrobe_t       stb,
  input  logic [LOG_W-1:0] curLog,
  input  logic [LOG_W-1:0] prevLog,
  input  logic             coalesceOn,
  input  logic             delivered,
  output logic [1:0]       flags,
  output logic             irq,
  output logic             ackPend,
  output logic [CNT_W-1:0] coalCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] baseCount;
  logic [CNT_W-1:0] nextCount;
  logic [1:0]       flagsAfterRd;
  logic             keepOnRead;
  logic             incCount;
  logic             decCount;

  function automatic logic [CNT_W-1:0] rescale(input logic [CNT_W-1:0] c,
                                               input logic [LOG_W-1:0] oldL,
                                               input logic [LOG_W-1:0] newL);
    logic [2*CNT_W-1:0] wide;
    if (newL >= oldL) return c >> (newL - oldL);
    wide = {{CNT_W{1'b0}}, c} << (oldL - newL);
    if (wide[2*CNT_W-1:CNT_W] != '0) return CNT_MAX;
    return wide[CNT_W-1:0];
  endfunction

  always_comb begin
    baseCount    = stb.rateChange ? rescale(coalCount, prevLog, curLog) : coalCount;
    keepOnRead   = stb.rdStatus && (coalCount != '0);
    flagsAfterRd = (stb.rdStatus && !keepOnRead) ? 2'b00 : flags;
    incCount     = stb.fire && coalesceOn && (flagsAfterRd != 2'b00);
    decCount     = ackPend && delivered && (baseCount != '0);
    nextCount    = baseCount;
    if (incCount && !decCount && baseCount != CNT_MAX) nextCount = baseCount + CNT_W'(1);
    if (decCount && !incCount) nextCount = baseCount - CNT_W'(1);
    if (stb.clearCount) nextCount = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags     <= 2'b00;
      irq       <= 1'b0;
      ackPend   <= 1'b0;
      coalCount <= '0;
    end else begin
      flags     <= stb.fire ? 2'b11 : flagsAfterRd;
      if (stb.fire) irq <= 1'b1;
      else if (stb.rdStatus) irq <= keepOnRead;
      ackPend   <= keepOnRead;
      coalCount <= nextCount;
    end
  end
endmodule

// File: rtl/pit_coalesce.sv
module pit_coalesce
  import pit_pkg::*;
#(
  parameter int TICK_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [3:0]  rateCode,
  input  logic        periodicOn,
  input  logic        coalesceOn,
  input  logic        statusRd,
  input  logic        delivered,
  output logic [7:0]  statusData,
  output logic        irqOut
);
  pitStrobe_t       stb;
  logic [LOG_W-1:0] curLog;
  logic [LOG_W-1:0] prevLog;
  logic [1:0]       flags;
  logic             ackPend;
  logic [CNT_W-1:0] coalCount;

  pit_ctrl #(.TICK_W(TICK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateCode(rateCode),
    .periodicOn(periodicOn), .statusRd(statusRd),
    .stb(stb), .curLog(curLog), .prevLog(prevLog)
  );

  pit_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .curLog(curLog), .prevLog(prevLog),
    .coalesceOn(coalesceOn), .delivered(delivered),
    .flags(flags), .irq(irqOut), .ackPend(ackPend), .coalCount(coalCount)
  );

  assign statusData = {flags, 6'b000000};
endmodule

// File: rtl/pit_coalesce_chk.sv
module pit_coalesce_chk
  import pit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input pitStrobe_t       stb,
  input logic             coalesceOn,
  input logic             ackPend,
  input logic [CNT_W-1:0] coalCount,
  input logic [7:0]       statusData,
  input logic             irqOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!irqOut && statusData == 8'h00));

  a_r4_fire_sets: assert property (@(posedge clk) disable iff (!rstN)
    stb.fire |=> (irqOut && statusData == 8'hC0));

  a_r5_coalesce_count: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && coalesceOn && statusData != 8'h00 && !stb.rdStatus && !ackPend &&
     !stb.rateChange && !stb.clearCount && coalCount != CNT_MAX)
    |=> (coalCount == $past(coalCount) + CNT_W'(1)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStatus && coalCount == '0 && !stb.fire) |=> (!irqOut && statusData == 8'h00));

  a_r7_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStatus && coalCount != '0 && !stb.clearCount) |=> (irqOut && statusData == 8'hC0));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearCount |=> (coalCount == '0));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (coalCount == CNT_MAX && !ackPend && !stb.rateChange && !stb.clearCount)
    |=> (coalCount == CNT_MAX));
endmodule

bind pit_coalesce pit_coalesce_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .coalesceOn(coalesceOn), .ackPend(ackPend),
  .coalCount(coalCount), .statusData(statusData), .irqOut(irqOut)
);

// File: tb/pit_coalesce_tb.sv
module pit_coalesce_tb;
  localparam int TB_CNT_W = 8;
  localparam int CMAX = 255;

  logic clk = 0;
  logic rstN = 0;
  logic tickEn = 0;
  logic [3:0] rateCode = 0;
  logic periodicOn = 0, coalesceOn = 0, statusRd = 0, delivered = 0;
  logic [7:0] statusData;
  logic irqOut;

  int errors = 0, checks = 0;
  bit done = 0, cmpOn = 0;

  // bench model state
  int unsigned mTick = 0, mStored = 0, mCount = 0;
  bit mFlags = 0, mIrq = 0, mAck = 0;

  always #2.5 clk = ~clk;

  pit_coalesce #(.TICK_W(16), .CNT_W(TB_CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateCode(rateCode),
    .periodicOn(periodicOn), .coalesceOn(coalesceOn), .statusRd(statusRd),
    .delivered(delivered), .statusData(statusData), .irqOut(irqOut)
  );

  function automatic int unsigned periodOf(input logic [3:0] code);
    int c = (code < 3) ? code + 7 : code;
    return 1 << (c - 1);
  endfunction

  always @(posedge clk) begin : model
    if (!rstN) begin
      mTick = 0; mStored = 1; mCount = 0; mFlags = 0; mIrq = 0; mAck = 0;
    end else begin
      bit en, fire, chg, keep, fAfter, inc, dec;
      int unsigned p;
      longint base;
      en = periodicOn && rateCode != 0;
      p = periodOf(rateCode);
      fire = tickEn && en && (((mTick + 1) % p) == 0);
      chg = en && p != mStored;
      base = mCount;
      if (chg) begin
        base = (longint'(mCount) * mStored) / p;
        if (base > CMAX) base = CMAX;
      end
      keep = statusRd && mCount != 0;
      fAfter = (statusRd && !keep) ? 1'b0 : mFlags;
      inc = fire && coalesceOn && fAfter;
      dec = mAck && delivered && base != 0;
      if (inc && !dec && base < CMAX) base = base + 1;
      if (dec && !inc) base = base - 1;
      if (!en) base = 0;
      if (fire) mIrq = 1; else if (statusRd) mIrq = keep;
      mFlags = fire ? 1'b1 : fAfter;
      mAck = keep;
      mCount = int'(base);
      if (en) mStored = p;
      if (tickEn) mTick = (mTick + 1) % 65536;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmpOn && rstN) begin
    check("R4 random status", statusData, mFlags ? 8'hC0 : 8'h00);
    check("R7 random line", irqOut, mIrq);
  end

  task automatic step(); @(negedge clk); endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tickEn = 1; step(); end
    tickEn = 0;
  endtask

  task automatic doRead(input bit ack, output logic [7:0] seen);
    statusRd = 1; delivered = 0;
    #1 seen = statusData;
    step();
    statusRd = 0; delivered = ack;
    step();
    delivered = 0;
  endtask

  task automatic drain(output int kept);
    logic [7:0] seen;
    kept = 0;
    for (int i = 0; i < 400; i++) begin
      doRead(1, seen);
      if (statusData == 8'hC0) kept++;
      else break;
    end
  endtask

  task automatic measure(input logic [3:0] code, input string tag);
    logic [7:0] seen;
    int k;
    rateCode = code; periodicOn = 1; coalesceOn = 0; step();
    doRead(0, seen);
    for (int i = 0; i < 600 && !irqOut; i++) ticks(1);
    doRead(0, seen);
    k = 0;
    for (int i = 0; i < 600; i++) begin ticks(1); k++; if (irqOut) break; end
    check(tag, k, periodOf(code));
  endtask

  initial begin : main
    logic [7:0] seen;
    int kept;
    void'($urandom(32'd1234));
    step(); step();
    check("R1 reset status", statusData, 0);
    check("R1 reset line", irqOut, 0);
    rstN = 1; step();
    check("R1 after reset line", irqOut, 0);

    // R3 alignment: two ticks while disabled, then enable with period 4
    ticks(2);
    rateCode = 3; periodicOn = 1; step();
    ticks(1);
    check("R3 no event before boundary", irqOut, 0);
    ticks(1);
    check("R3 event at boundary", irqOut, 1);
    check("R4 status flags", statusData, 8'hC0);

    // R6 read returns contents then clears
    doRead(0, seen);
    check("R6 read value", seen, 8'hC0);
    check("R6 cleared status", statusData, 0);
    check("R6 line lowered", irqOut, 0);

    // R5 without coalescing: second event while pending, one read clears
    coalesceOn = 0; ticks(8);
    check("R5 line held", irqOut, 1);
    drain(kept);
    check("R5 no count without coalesce", kept, 0);

    // R7 replay gated by delivered
    coalesceOn = 1; ticks(12);
    doRead(0, seen);
    check("R7 kept flags", statusData, 8'hC0);
    check("R7 line re-raised", irqOut, 1);
    doRead(1, seen);
    check("R7 kept after first ack", statusData, 8'hC0);
    doRead(1, seen);
    check("R7 kept with count 1", statusData, 8'hC0);
    doRead(0, seen);
    check("R7 cleared after count used", statusData, 0);

    // R2 periods
    measure(4'd1, "R2 code1");
    measure(4'd2, "R2 code2");
    measure(4'd3, "R2 code3");
    measure(4'd7, "R2 code7");

    // R8 rescale down and up
    rateCode = 3; coalesceOn = 1; step(); drain(kept);
    ticks(20);
    rateCode = 5; step();
    drain(kept);
    check("R8 rescale 4*4/16", kept, 1);
    ticks(32);
    rateCode = 3; step();
    drain(kept);
    check("R8 rescale 1*16/4", kept, 4);

    // R9 disable clears count; code 0 gives no events
    ticks(12);
    periodicOn = 0; step(); periodicOn = 1; step();
    drain(kept);
    check("R9 count cleared by disable", kept, 0);
    rateCode = 0; ticks(100);
    check("R9 no event at code 0", irqOut, 0);

    // R10 saturation on rescale
    rateCode = 10; step(); drain(kept);
    ticks(2048);
    rateCode = 3; step();
    drain(kept);
    check("R10 saturated count", kept, CMAX);

    // random phase compared against the model
    cmpOn = 1;
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom % 100;
      tickEn = ($urandom % 2) == 1;
      statusRd = ($urandom % 8) == 0;
      delivered = ($urandom % 2) == 1;
      if (r < 2) rateCode = 4'($urandom % 7);
      if (r == 50) periodicOn = !periodicOn;
      if (r == 60) coalesceOn = !coalesceOn;
      if (r > 97) periodicOn = 1;
      step();
    end
    cmpOn = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule